// File: doc/BRIEF.md
# Received-Event Upload Poller

This block sits between a powerline receiver and a host serial link. While a powerline reception is in progress it stores the incoming event bytes, up to eight of them. Each byte is tagged as either an address or a function. When a reception starts and the ring enable input is high, it raises a ring output to wake the host. When the reception ends, it offers a poll byte (0x5A) on a valid/ready byte transmit port. It repeats the poll once per one-second tick until the host answers with 0xC3.

On that answer the ring output drops and the block uploads a frame. The frame is a length byte, then a mask byte that says which data bytes are functions, then the stored data bytes in arrival order. No acknowledgement follows the frame. The store is emptied as the last byte leaves, ready for the next reception. Demodulation and the UART sit outside the block.

The sequencer has seven states. IDLE waits for a reception to start. RECV stores event bytes. POLL_TX offers the poll byte. POLL_WAIT waits for the host answer or the next tick. LEN_TX, MASK_TX and DATA_TX send the frame.

The transitions are:
- IDLE to RECV on a reception start.
- RECV to POLL_TX on reception done.
- POLL_TX to POLL_WAIT when the poll byte is taken.
- POLL_WAIT to LEN_TX on a host 0xC3.
- POLL_WAIT to POLL_TX on a second tick without a host 0xC3.
- LEN_TX to MASK_TX when the length byte is taken.
- MASK_TX to IDLE when the store is empty, otherwise MASK_TX to DATA_TX.
- DATA_TX stays in DATA_TX until the last data byte is taken, then goes to IDLE.

Top module: `evt_upload_poller`

## Requirements
- R1: After reset, ring_out is 0 and tx_valid is 0.
- R2: A rx_start pulse in IDLE sets ring_out on the next cycle when ring_en is 1. When ring_en is 0, ring_out stays 0.
- R3: One cycle after rx_done, tx_valid is 1 with tx_data = 0x5A. After a poll byte is taken, tx_valid stays 0 until a sec_tick. The cycle after that tick, 0x5A is offered again.
- R4: A host byte other than 0xC3 during polling is ignored. ring_out and tx_valid keep their values, and the next tick still brings a 0x5A.
- R5: A host byte 0xC3 in POLL_WAIT clears ring_out on the next cycle, and the length byte is offered in that same cycle.
- R6: The length byte equals the number of stored data bytes plus one, because it counts the mask byte.
- R7: Mask bit i (bit 0 = first stored byte) is 1 when stored byte i arrived with rx_func = 1 and 0 when it arrived with rx_func = 0. Mask bits for unstored positions are 0.
- R8: After the mask byte, exactly the stored data bytes are sent, in arrival order. tx_valid is 0 in the cycle after the last one is taken.
- R9: Once 8 bytes are stored, further rx_valid bytes in the same reception are dropped. The frame then has length 9 and carries the first 8 bytes.
- R10: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data holds its value.
- R11: A finished upload empties the store. A following reception with no bytes uploads length 1 and mask 0.
- R12: rx_valid bytes presented outside a reception (in IDLE) are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_en | input | 1 | Allows ring_out to be raised at reception start |
| rx_start | input | 1 | Pulse: powerline reception begins |
| rx_valid | input | 1 | Event byte present on rx_data |
| rx_data | input | 8 | Received event byte |
| rx_func | input | 1 | 1 = event byte is a function, 0 = address |
| rx_done | input | 1 | Pulse: powerline reception complete |
| sec_tick | input | 1 | One-cycle pulse once per second |
| host_valid | input | 1 | Host byte present on host_data |
| host_data | input | 8 | Byte received from the host |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |
| tx_valid | output | 1 | Byte offered on tx_data |
| tx_data | output | 8 | Byte to transmit to the host |
| ring_out | output | 1 | Wake request to the host |

## Verification
The bench goes after the edges of the store. An empty reception must yield length 1. Exactly eight bytes must fill the store, and eleven bytes must show that only the first eight are kept; a store that wrapped or kept counting would send a length past 9 or overwrite early bytes. Polling is checked under random non-0xC3 host bytes, which a careless decoder would take as an answer and so upload early, and under missing ticks, where a free-running poll would offer 0x5A without waiting. Transmit back-pressure checks that tx_data is held, and a reception that follows an upload exposes a mask or count that was never cleared.

// File: rtl/evt_pkg.sv
package evt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_POLL_TX,
        ST_POLL_WAIT,
        ST_LEN_TX,
        ST_MASK_TX,
        ST_DATA_TX
    } seq_state_t;

    localparam logic [7:0] POLL_CODE = 8'h5A;
    localparam logic [7:0] HOST_ACK  = 8'hC3;
endpackage

// File: rtl/evt_store.sv
module evt_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             wr_func,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] cnt,
    output logic [DEPTH-1:0] mask
);
    logic [W-1:0] slot_q [DEPTH];
    logic         full;

    assign full = (cnt == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (wr_en && !full)
            cnt <= cnt + CNT_W'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic take;
        logic fbit_q;
        assign take = wr_en && !clr && (cnt == CNT_W'(i));
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                fbit_q <= 1'b0;
            else if (take)
                fbit_q <= wr_func;
        end
        always_ff @(posedge clk) begin
            if (take)
                slot_q[i] <= wr_data;
        end
        assign mask[i] = fbit_q;
    end

    assign rd_data = slot_q[rd_idx];

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && full) |=> ($stable(cnt) && $stable(mask)));

    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && mask == '0));
endmodule

// File: rtl/upload_seq.sv
module upload_seq
    import evt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_en,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic             rx_done,
    input  logic             sec_tick,
    input  logic             host_valid,
    input  logic [7:0]       host_data,
    input  logic             tx_ready,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DEPTH-1:0] mask,
    input  logic [W-1:0]     rd_data,
    output logic             st_wr,
    output logic             st_clr,
    output logic [IDX_W-1:0] rd_idx,
    output logic             ring_out,
    output logic             tx_valid,
    output logic [W-1:0]     tx_data
);
    seq_state_t state, nxt;
    logic [IDX_W-1:0] idx;
    logic fire, ack, last;

    assign fire = tx_valid && tx_ready;
    assign ack  = host_valid && (host_data == HOST_ACK);
    assign last = ((CNT_W'(idx) + CNT_W'(1)) == cnt);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (rx_start) nxt = ST_RECV;
            ST_RECV:      if (rx_done) nxt = ST_POLL_TX;
            ST_POLL_TX:   if (fire) nxt = ST_POLL_WAIT;
            ST_POLL_WAIT: if (ack) nxt = ST_LEN_TX;
                          else if (sec_tick) nxt = ST_POLL_TX;
            ST_LEN_TX:    if (fire) nxt = ST_MASK_TX;
            ST_MASK_TX:   if (fire) nxt = (cnt == '0) ? ST_IDLE : ST_DATA_TX;
            ST_DATA_TX:   if (fire && last) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (state == ST_MASK_TX)
            idx <= '0;
        else if (state == ST_DATA_TX && fire && !last)
            idx <= idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_out <= 1'b0;
        else if (state == ST_IDLE && rx_start && ring_en)
            ring_out <= 1'b1;
        else if (state == ST_POLL_WAIT && ack)
            ring_out <= 1'b0;
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        unique case (state)
            ST_POLL_TX: begin tx_valid = 1'b1; tx_data = W'(POLL_CODE); end
            ST_LEN_TX:  begin tx_valid = 1'b1; tx_data = W'(cnt) + W'(1); end
            ST_MASK_TX: begin tx_valid = 1'b1; tx_data = W'(mask); end
            ST_DATA_TX: begin tx_valid = 1'b1; tx_data = rd_data; end
            default:    begin tx_valid = 1'b0; tx_data = '0; end
        endcase
    end

    assign st_wr  = (state == ST_RECV) && rx_valid;
    assign st_clr = fire && ((state == ST_MASK_TX && cnt == '0) ||
                             (state == ST_DATA_TX && last));
    assign rd_idx = idx;

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R5
    ring_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ring_out) |-> $past(ack));

    // R2
    ring_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_out) |-> $past(rx_start && ring_en));

    // R3
    poll_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_WAIT && !sec_tick && !host_valid) |=> !tx_valid);

    // R8
    upload_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_clr |=> !tx_valid);
endmodule

// File: rtl/evt_upload_poller.sv
module evt_upload_poller #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ring_en,
    input  logic         rx_start,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_func,
    input  logic         rx_done,
    input  logic         sec_tick,
    input  logic         host_valid,
    input  logic [7:0]   host_data,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         ring_out
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             st_wr, st_clr;
    logic [IDX_W-1:0] rd_idx;
    logic [W-1:0]     rd_data;
    logic [CNT_W-1:0] cnt;
    logic [DEPTH-1:0] mask;

    evt_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr),
        .wr_data (rx_data),
        .wr_func (rx_func),
        .clr     (st_clr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cnt     (cnt),
        .mask    (mask)
    );

    upload_seq #(.DEPTH(DEPTH), .W(W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_en    (ring_en),
        .rx_start   (rx_start),
        .rx_valid   (rx_valid),
        .rx_done    (rx_done),
        .sec_tick   (sec_tick),
        .host_valid (host_valid),
        .host_data  (host_data),
        .tx_ready   (tx_ready),
        .cnt        (cnt),
        .mask       (mask),
        .rd_data    (rd_data),
        .st_wr      (st_wr),
        .st_clr     (st_clr),
        .rd_idx     (rd_idx),
        .ring_out   (ring_out),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data)
    );
endmodule

// File: tb/test_evt_upload_poller.sv
module test_evt_upload_poller;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_en = 1'b0, rx_start = 1'b0, rx_valid = 1'b0, rx_func = 1'b0;
    logic       rx_done = 1'b0, sec_tick = 1'b0, host_valid = 1'b0, tx_ready = 1'b0;
    logic [7:0] rx_data = '0, host_data = '0;
    logic       tx_valid, ring_out;
    logic [7:0] tx_data;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    evt_upload_poller i_evt_upload_poller (
        .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .rx_start(rx_start),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_func(rx_func), .rx_done(rx_done),
        .sec_tick(sec_tick), .host_valid(host_valid), .host_data(host_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .ring_out(ring_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] exp_mask(input bit f[12], input int m);
        logic [7:0] r = '0;
        for (int i = 0; i < m; i++) r[i] = f[i];
        return r;
    endfunction

    task automatic take_byte(input logic [7:0] exp, input string req);
        int waited = 0;
        @(negedge clk);
        while (!tx_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        chk(tx_valid && tx_data == exp, req, tx_data, exp);
        for (int k = 0; k < int'($urandom % 3); k++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == exp, "R10", tx_data, exp);
        end
        tx_ready = 1'b1;
        @(posedge clk);
        #1 tx_ready = 1'b0;
    endtask

    task automatic session(input int n, input logic [7:0] d[12], input bit f[12],
                           input bit ren, input int noise, input bit junk);
        int m = (n > 8) ? 8 : n;
        logic [7:0] hb;
        if (junk) begin
            rx_valid = 1'b1; rx_data = 8'hEE; rx_func = 1'b1;
            step();
            rx_valid = 1'b0;
        end
        ring_en = ren;
        rx_start = 1'b1;
        step();
        rx_start = 1'b0;
        @(negedge clk);
        chk(ring_out == ren, "R2", ring_out, ren);
        for (int i = 0; i < n; i++) begin
            #1;
            rx_valid = 1'b1; rx_data = d[i]; rx_func = f[i];
            step();
            rx_valid = 1'b0;
            if ($urandom % 2) step();
        end
        rx_done = 1'b1;
        step();
        rx_done = 1'b0;
        take_byte(8'h5A, "R3");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!tx_valid, "R3", tx_valid, 0);
        end
        for (int q = 0; q < noise; q++) begin
            #1;
            hb = 8'($urandom);
            if (hb == 8'hC3) hb = 8'h3C;
            host_valid = 1'b1; host_data = hb;
            step();
            host_valid = 1'b0;
            @(negedge clk);
            chk(!tx_valid && ring_out == ren, "R4", {tx_valid, ring_out}, {1'b0, ren});
            #1 sec_tick = 1'b1;
            step();
            sec_tick = 1'b0;
            take_byte(8'h5A, "R4");
        end
        #1;
        host_valid = 1'b1; host_data = 8'hC3;
        step();
        host_valid = 1'b0;
        @(negedge clk);
        chk(ring_out == 1'b0, "R5", ring_out, 0);
        chk(tx_valid, "R5", tx_valid, 1);
        take_byte(8'(m + 1), (n > 8) ? "R9" : "R6");
        take_byte(exp_mask(f, m), (n == 0) ? "R11" : "R7");
        for (int i = 0; i < m; i++) take_byte(d[i], (n > 8) ? "R9" : "R8");
        @(negedge clk);
        chk(!tx_valid, "R8", tx_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d[12];
        bit f[12];
        void'($urandom(32'd4242));
        repeat (3) step();
        @(negedge clk);
        chk(ring_out == 0 && tx_valid == 0, "R1", {ring_out, tx_valid}, 0);
        #1 rst_n = 1'b1;
        step();
        for (int i = 0; i < 12; i++) begin
            d[i] = 8'(8'h10 + i * 7);
            f[i] = (i % 3 == 2);
        end
        session(5, d, f, 1'b1, 1, 1'b1);   // R12 junk in IDLE
        session(0, d, f, 1'b1, 0, 1'b0);   // R11 empty after upload
        session(8, d, f, 1'b0, 2, 1'b0);   // full store, ring disabled
        session(11, d, f, 1'b1, 1, 1'b1);  // R9 overflow
        for (int s = 0; s < 30; s++) begin
            for (int i = 0; i < 12; i++) begin
                d[i] = 8'($urandom);
                f[i] = 1'($urandom);
            end
            session(int'($urandom % 12), d, f, 1'($urandom), int'($urandom % 3), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule